// File: doc/BRIEF.md
# Wakeup Alarm Timer

This block is a 16-bit up-counter that serves as a wakeup alarm in a low-power domain. A slow reference tick arrives as a one-cycle enable pulse on the system clock. A power-of-two prescaler divides that tick. Each prescaled tick advances the counter from a programmable start value toward a programmable limit. On the tick after the counter equals the limit, the counter reloads the start value and a sticky wrap flag is set.

When the wrap flag and its enable bit are both set, the block raises a level interrupt. Software programs and polls the block through a plain 32-bit register read/write port. To arm a delay of N prescaled ticks, software sets the start value to 0 and the limit to N-1, then selects the reference tick as the count source.

A write of any data to the count register restarts the counter from the start value. Software clears the flag by writing 0 to its bit.

Top module: `wakeup_alarm_timer`

## Requirements
- R1: After reset, the control register reads 0, the count reads 0, the limit reads 0xFFFF, the start value reads 0 and `irq` is low.
- R2: The register offsets are: control at 0x00, count at 0x04, limit at 0x08 and start value at 0x4C. Read data appears on `rd_data` in the cycle after `rd_en` and reflects the state before that edge. Unused upper bits read as zero. Unmapped offsets read as zero.
- R3: The control register holds the prescale exponent in bits [2:0], the source select in bits [4:3], the interrupt enable in bit 6 and the wrap flag in bit 7. Only a source select of 2 lets the counter advance. Values 0, 1 and 3 hold the counter.
- R4: With the reference source selected, one count tick occurs for every 2^P reference pulses, where P is the prescale exponent (0 to 7).
- R5: On each count tick the counter increments by one unless it equals the limit. In that case it loads the start value on that tick.
- R6: The wrap flag is set on the same edge at which the counter moves from the limit to the start value.
- R7: A bus write to the count register loads the start value and ignores the written data. In the same cycle it takes priority over a count tick, and that tick is dropped without setting the flag.
- R8: Writing 0 to bit 7 of the control register clears the wrap flag. Writing 1 leaves it unchanged. If a wrap and a clearing write occur in the same cycle, the flag ends up set.
- R9: `irq` is registered and equals (wrap flag AND interrupt enable) as they stood one cycle earlier. It stays high as long as both are set.
- R10: A control write that changes the prescale exponent or the source select restarts the prescaler. The next count tick then needs a full 2^P reference pulses, and a pulse arriving in the writing cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse from the fixed-frequency reference |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, wrap flag AND enable |

## Verification
The count, the wrap flag and the control fields change on the same edge that samples a reference pulse or a write. Read data for a strobe is valid one edge later and shows the state before that edge. `irq` trails the flag and its enable by exactly one edge. The bench drives each stimulus for one cycle and samples 1 ns after the following rising edge. At that point it compares `rd_data` with a reference model's register image taken before the update, and compares `irq` with the model's flag AND enable from the previous cycle. The directed cases force the same-cycle collisions: a count write against a tick, a clearing write against a wrap, and a control change against a terminal prescaler pulse.

// File: rtl/wat_pkg.sv
package wat_pkg;
  localparam int PS_W = 3;
  localparam int SRC_W = 2;
  localparam int CTRL_W = 8;

  localparam int OFS_CTRL = 'h00;
  localparam int OFS_CNT  = 'h04;
  localparam int OFS_MOD  = 'h08;
  localparam int OFS_INIT = 'h4C;

  typedef enum logic [SRC_W-1:0] {
    SRC_OFF  = 2'd0,
    SRC_RSV1 = 2'd1,
    SRC_REF  = 2'd2,
    SRC_RSV3 = 2'd3
  } src_e;

  typedef struct packed {
    logic            flag;
    logic            ie;
    logic            rsv;
    src_e            src;
    logic [PS_W-1:0] ps;
  } ctrl_t;
endpackage

// File: rtl/wat_prescaler.sv
module wat_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ref_tick,
  input  logic            run,
  input  logic [PS_W-1:0] ps,
  input  logic            restart,
  output logic            count_tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;
  logic             hit;

  always_comb begin
    limit = ~({DIV_W{1'b1}} << ps);
    hit   = (div_q == limit);
    count_tick = run & ref_tick & ~restart & hit;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      div_q <= '0;
    end else if (run && ref_tick) begin
      div_q <= hit ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/wat_counter.sv
module wat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             count_tick,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] init_val,
  input  logic [CNT_W-1:0] mod_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic at_limit;

  always_comb begin
    at_limit = (cnt == mod_val);
    wrap     = count_tick & ~cnt_load & at_limit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt_load) begin
      cnt <= init_val;
    end else if (count_tick) begin
      cnt <= at_limit ? init_val : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wat_regs.sv
module wat_regs
  import wat_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wrap,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  mod_val,
  output logic [CNT_W-1:0]  init_val,
  output logic              cnt_load,
  output logic              restart,
  output logic [DATA_W-1:0] rd_data
);
  logic sel_ctrl, sel_cnt, sel_mod, sel_init;
  logic ctrl_wr;
  ctrl_t wr_ctrl;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    sel_ctrl = (addr == ADDR_W'(OFS_CTRL));
    sel_cnt  = (addr == ADDR_W'(OFS_CNT));
    sel_mod  = (addr == ADDR_W'(OFS_MOD));
    sel_init = (addr == ADDR_W'(OFS_INIT));
    ctrl_wr  = wr_en & sel_ctrl;
    cnt_load = wr_en & sel_cnt;
    wr_ctrl  = ctrl_t'(wdata[CTRL_W-1:0]);
    restart  = ctrl_wr & ((wr_ctrl.ps != ctrl.ps) | (wr_ctrl.src != ctrl.src));
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl) begin
      rd_mux = DATA_W'({ctrl.flag, ctrl.ie, 1'b0, ctrl.src, ctrl.ps});
    end else if (sel_cnt) begin
      rd_mux = DATA_W'(cnt);
    end else if (sel_mod) begin
      rd_mux = DATA_W'(mod_val);
    end else if (sel_init) begin
      rd_mux = DATA_W'(init_val);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      mod_val  <= '1;
      init_val <= '0;
      rd_data  <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl.ps  <= wr_ctrl.ps;
        ctrl.src <= wr_ctrl.src;
        ctrl.ie  <= wr_ctrl.ie;
      end
      ctrl.rsv  <= 1'b0;
      ctrl.flag <= wrap | (ctrl.flag & ~(ctrl_wr & ~wr_ctrl.flag));
      if (wr_en && sel_mod) begin
        mod_val <= wdata[CNT_W-1:0];
      end
      if (wr_en && sel_init) begin
        init_val <= wdata[CNT_W-1:0];
      end
      if (rd_en) begin
        rd_data <= rd_mux;
      end
    end
  end
endmodule

// File: rtl/wakeup_alarm_timer.sv
module wakeup_alarm_timer
  import wat_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mod_val;
  logic [CNT_W-1:0] init_val;
  logic             cnt_load;
  logic             restart;
  logic             count_tick;
  logic             wrap;
  logic             flag;
  logic             irq_en;
  src_e             src;

  assign flag   = ctrl.flag;
  assign irq_en = ctrl.ie;
  assign src    = ctrl.src;

  wat_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt(cnt), .wrap(wrap), .ctrl(ctrl), .mod_val(mod_val),
    .init_val(init_val), .cnt_load(cnt_load), .restart(restart),
    .rd_data(rd_data)
  );

  wat_prescaler #(.PS_W(PS_W)) u_presc (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .run(src == SRC_REF),
    .ps(ctrl.ps), .restart(restart), .count_tick(count_tick)
  );

  wat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .count_tick(count_tick), .cnt_load(cnt_load),
    .init_val(init_val), .mod_val(mod_val), .cnt(cnt), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else begin
      irq <= flag & irq_en;
    end
  end
endmodule

// File: rtl/wakeup_alarm_timer_chk.sv
module wakeup_alarm_timer_chk
  import wat_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ref_tick,
  input logic             count_tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] mod_val,
  input logic [CNT_W-1:0] init_val,
  input logic             cnt_load,
  input logic             wrap,
  input logic             flag,
  input logic             irq_en,
  input logic             irq,
  input src_e             src
);
  p_stopped_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (src != SRC_REF && !cnt_load) |=> $stable(cnt));

  p_tick_needs_ref_r4: assert property (@(posedge clk) disable iff (rst)
    count_tick |-> (ref_tick && src == SRC_REF));

  p_limit_reload_r5: assert property (@(posedge clk) disable iff (rst)
    (count_tick && !cnt_load && cnt == mod_val) |=> (cnt == $past(init_val) && flag));

  p_flag_source_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(wrap));

  p_load_init_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_load |=> (cnt == $past(init_val)));

  p_wrap_wins_r8: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag);

  p_irq_level_r9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq == $past(flag && irq_en)));
endmodule

bind wakeup_alarm_timer wakeup_alarm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ref_tick(ref_tick), .count_tick(count_tick),
  .cnt(cnt), .mod_val(mod_val), .init_val(init_val), .cnt_load(cnt_load),
  .wrap(wrap), .flag(flag), .irq_en(irq_en), .irq(irq), .src(src)
);

// File: tb/wakeup_alarm_timer_test.sv
`timescale 1ns/1ps
module wakeup_alarm_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [2:0]  m_ps = 0;
  logic [1:0]  m_src = 0;
  logic        m_ie = 0, m_flag = 0;
  logic [15:0] m_cnt = 0, m_mod = 16'hFFFF, m_init = 0;
  logic [6:0]  m_div = 0;

  wakeup_alarm_timer uut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00:   return {24'b0, m_flag, m_ie, 1'b0, m_src, m_ps};
      8'h04:   return {16'b0, m_cnt};
      8'h08:   return {16'b0, m_mod};
      8'h4C:   return {16'b0, m_init};
      default: return 32'b0;
    endcase
  endfunction

  task automatic step(input string tag, input logic tk, input logic we, input logic re,
                      input logic [7:0] a, input logic [31:0] d);
    logic [31:0] exp_rd;
    logic exp_irq, ctrl_wr, restart, ctick, wrap;
    ref_tick = tk; wr_en = we; rd_en = re; addr = a; wdata = d;
    @(posedge clk); #1;
    exp_rd  = model_read(a);
    exp_irq = m_flag & m_ie;
    ctrl_wr = we && a == 8'h00;
    restart = ctrl_wr && (d[2:0] != m_ps || d[4:3] != m_src);
    ctick = 0;
    if (restart) m_div = 0;
    else if (m_src == 2'd2 && tk) begin
      if (m_div == 7'((1 << m_ps) - 1)) begin ctick = 1; m_div = 0; end
      else m_div = m_div + 1;
    end
    wrap = 0;
    if (we && a == 8'h04) m_cnt = m_init;
    else if (ctick) begin
      if (m_cnt == m_mod) begin m_cnt = m_init; wrap = 1; end
      else m_cnt = m_cnt + 1;
    end
    if (wrap) m_flag = 1;
    else if (ctrl_wr && !d[7]) m_flag = 0;
    if (ctrl_wr) begin m_ps = d[2:0]; m_src = d[4:3]; m_ie = d[6]; end
    if (we && a == 8'h08) m_mod = d[15:0];
    if (we && a == 8'h4C) m_init = d[15:0];
    check("R9 irq", {31'b0, irq}, {31'b0, exp_irq});
    if (re) check(tag, rd_data, exp_rd);
    ref_tick = 0; wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step("R2", 1'b0, 1'b1, 1'b0, a, d);
  endtask
  task automatic rd(input string tag, input logic [7:0] a);
    step(tag, 1'b0, 1'b0, 1'b1, a, 32'b0);
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step("R4", 1'b1, 1'b0, 1'b0, 8'h00, 32'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset values
    rd("R1 ctrl", 8'h00); rd("R1 cnt", 8'h04); rd("R1 mod", 8'h08); rd("R1 init", 8'h4C);
    check("R1 irq", {31'b0, irq}, 32'b0);
    // R2 unmapped read and upper bits
    rd("R2 unmapped", 8'h10);
    wr(8'h08, 32'hABCD_0003);
    rd("R2 upper zero", 8'h08);
    // R3 stopped sources hold the counter
    wr(8'h00, 32'h0000_0008);
    ticks(5); rd("R3 src1 hold", 8'h04);
    wr(8'h00, 32'h0000_0018);
    ticks(5); rd("R3 src3 hold", 8'h04);
    // R5/R6 count to limit 3 then reload, flag set, irq level
    wr(8'h00, 32'h0000_0050);
    ticks(3); rd("R5 cnt at limit", 8'h04);
    ticks(1); rd("R6 flag set", 8'h00); rd("R5 reload", 8'h04);
    rd("R9 hold", 8'h00);
    // R8 write 1 to flag keeps it, write 0 clears
    wr(8'h00, 32'h0000_00D0); rd("R8 write one", 8'h00);
    wr(8'h00, 32'h0000_0050); rd("R8 cleared", 8'h00);
    // R7 count write loads init, ignores data, beats tick
    wr(8'h4C, 32'h0000_0002);
    step("R7", 1'b1, 1'b1, 1'b0, 8'h04, 32'h0000_1234);
    rd("R7 load init", 8'h04);
    // R8 wrap and clearing write collide: cnt 2 -> 3 then wrap cycle
    ticks(1);
    step("R8", 1'b1, 1'b1, 1'b0, 8'h00, 32'h0000_0050);
    rd("R8 wrap wins", 8'h00);
    wr(8'h00, 32'h0000_0050);
    // R4 prescale 2^2
    wr(8'h08, 32'h0000_FFFF); wr(8'h4C, 32'h0); wr(8'h04, 32'h0);
    wr(8'h00, 32'h0000_0052);
    ticks(11); rd("R4 div4", 8'h04);
    // R10 change ps restarts divider
    ticks(2);
    wr(8'h00, 32'h0000_0051);
    ticks(1); rd("R10 restart", 8'h04);
    ticks(1); rd("R10 full period", 8'h04);
    step("R10", 1'b1, 1'b1, 1'b0, 8'h00, 32'h0000_0050);
    rd("R10 same-cycle pulse", 8'h04);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [7:0] a;
      logic [31:0] d;
      r = $urandom_range(0, 99);
      case ($urandom_range(0, 4))
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h4C; default: a = 8'h20;
      endcase
      d = $urandom;
      if (a == 8'h00) d[2:0] = 3'($urandom_range(0, 2));
      if (a == 8'h08) d[15:0] = 16'($urandom_range(0, 7));
      if (a == 8'h4C) d[15:0] = 16'($urandom_range(0, 3));
      if (a == 8'h00 && $urandom_range(0, 3) != 0) d[4:3] = 2'd2;
      if (r < 6) step("R2", $urandom_range(0, 1) == 1, 1'b1, 1'b0, a, d);
      else if (r < 30)
        step(a == 8'h00 ? "R6 rand ctrl" : (a == 8'h04 ? "R5 rand cnt" : "R2 rand"),
             $urandom_range(0, 1) == 1, 1'b0, 1'b1, a, 32'b0);
      else step("R4", $urandom_range(0, 2) != 0, 1'b0, 1'b0, 8'h00, 32'b0);
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #400000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule